// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Unit

This block runs the bus cycle that answers a pending interrupt. When it is asked to acknowledge a level from 1 to 7, it signals the acknowledge with an all-ones function code. It also puts the level on address lines 3..1 and drives every other address line high. It then asserts the address and lower data strobes and waits, for as many wait cycles as needed, for the interrupting device to respond. The result of the cycle is an 8-bit exception vector number, or an error indication.

A device answers in one of two ways. It can place its own vector on the low byte of the data bus and raise the data-acknowledge input. It can instead raise the autovector-request input, in which case the vector is formed inside the unit as 0x18 plus the level. A bus-error response, or both acknowledges arriving in the same cycle, ends the cycle with an error pulse and no vector. Priority masking and the exception handling that follows are left to the surrounding logic.

Top module: `irq_ack_unit`

## Requirements
- R1: While in reset and in the first cycle after reset: `as_n_o` and `lds_n_o` are 1, `vector_valid_o` and `error_o` are 0, `fc_o` is 000 and `addr_o` is all zeros.
- R2: A start request with level 000 is ignored. A start request that arrives while a cycle is running is also ignored. In both cases the strobes stay as they were and no result pulse appears.
- R3: From the cycle after an accepted start until the completion cycle: `fc_o` is 111, `addr_o[3:1]` holds the level, and every other bit of `addr_o` is 1.
- R4: In the first cycle after an accepted start, both strobes are 1. From the second cycle until a response is sampled, `as_n_o` and `lds_n_o` are both 0. Both return to 1 in the completion cycle.
- R5: Responses are sampled only while the strobes are low. Any number of cycles with no response keeps the strobes low (wait states).
- R6: A response with only `dtack_n_i` low (active-low) takes the vector from `data_i[7:0]`. `data_i[15:8]` has no effect.
- R7: A response with only `vpa_n_i` low takes the vector as 8'h18 plus the level.
- R8: `berr_n_i` low ends the cycle with `error_o` high for one cycle and `vector_valid_o` low. This holds whatever the other responses are.
- R9: `dtack_n_i` and `vpa_n_i` low together is a protocol error. It is reported like R8.
- R10: The completion cycle is the cycle after the response is sampled. In it, `vector_valid_o` (or `error_o`) is high for exactly one clock. The unit is idle in the following cycle and accepts a new start there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to acknowledge a level |
| level_i | input | 3 | Interrupt level, 1..7 |
| data_i | input | 16 | Data bus from the device |
| dtack_n_i | input | 1 | Data acknowledge, active low |
| vpa_n_i | input | 1 | Autovector request, active low |
| berr_n_i | input | 1 | Bus error, active low |
| addr_o | output | 24 | Address lines, bit i is line Ai |
| fc_o | output | 3 | Function code |
| as_n_o | output | 1 | Address strobe, active low |
| lds_n_o | output | 1 | Lower data strobe, active low |
| vector_valid_o | output | 1 | One-cycle pulse: vector_o is valid |
| vector_o | output | 8 | Exception vector number |
| error_o | output | 1 | One-cycle pulse: bus error or protocol error |

## Verification
Some outcomes need a response that lands in a precise cycle. These are a start request arriving while a long wait is in progress, both acknowledges arriving together, and a bus error arriving together with a valid acknowledge. The bench drives responses on the falling edge and counts the wait states it inserts. This lets it place each response, or an extra start request, at a known point in the wait phase. Random upper-byte data goes with every data-bus response, so that any leak of bits 15..8 into the vector shows up.

// File: rtl/iack_pkg.sv
// Shared types and constants for the interrupt acknowledge unit.
package iack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // bus released
        ST_ADDR,  // address and function code driven, strobes high
        ST_STRB,  // strobes asserted, responses not yet sampled
        ST_WAIT,  // strobes asserted, sampling responses
        ST_DONE   // strobes released, result pulse
    } iack_state_t;

    localparam int LVL_W = 3;
    localparam logic [7:0] AUTOVEC_BASE = 8'h18;
    localparam logic [2:0] FC_IACK = 3'b111;
endpackage

// File: rtl/iack_sequencer.sv
// Cycle sequencer: accepts a start with a nonzero level, steps through the
// address, strobe and wait phases, and classifies the response.
// Assumes the response inputs are already synchronous to clk.
module iack_sequencer
    import iack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             dtack_n_i,
    input  logic             vpa_n_i,
    input  logic             berr_n_i,
    output iack_state_t      state_o,
    output logic [LVL_W-1:0] level_o,
    output logic             take_o,     // response accepted this cycle
    output logic             use_auto_o, // accepted response is autovector
    output logic             ok_o,       // completion with vector
    output logic             err_o       // completion with error
);
    iack_state_t state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic ok_q, err_q;
    logic any_resp, bad_resp;

    // Classify the response lines (all active low).
    always_comb begin
        any_resp   = !dtack_n_i || !vpa_n_i || !berr_n_i;
        bad_resp   = !berr_n_i || (!dtack_n_i && !vpa_n_i);
        take_o     = (state_q == ST_WAIT) && any_resp;
        use_auto_o = !vpa_n_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && level_i != '0) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_STRB;
            ST_STRB: state_d = ST_WAIT;
            ST_WAIT: if (any_resp) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched level and outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i && level_i != '0)
                lvl_q <= level_i;
            else if (state_q == ST_DONE)
                lvl_q <= '0;
            ok_q  <= take_o && !bad_resp;
            err_q <= take_o && bad_resp;
        end
    end

    assign state_o = state_q;
    assign level_o = lvl_q;
    assign ok_o    = ok_q;
    assign err_o   = err_q;

    // R2: a zero level never leaves idle.
    a_r2_zero_level_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && level_i == '0) |=> (state_q == ST_IDLE));
    // R10: every completion returns to idle next cycle.
    a_r10_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/iack_addr_gen.sv
// Drives the bus address, function code and strobes from the sequencer state.
// Assumes level is stable for the whole cycle.
module iack_addr_gen
    import iack_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  iack_state_t      state_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [2:0]        fc_o,
    output logic              as_n_o,
    output logic              lds_n_o
);
    localparam int LVL_LO = 1;
    localparam int LVL_HI = LVL_LO + LVL_W - 1;

    logic in_cycle, strobing;

    // Phase decode.
    always_comb begin
        in_cycle = (state_i != ST_IDLE);
        strobing = (state_i == ST_STRB) || (state_i == ST_WAIT);
    end

    // Build each address line: level on lines LVL_HI..LVL_LO, ones elsewhere.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_line
        if (i >= LVL_LO && i <= LVL_HI) begin : g_lvl
            assign addr_o[i] = in_cycle & level_i[i-LVL_LO];
        end else begin : g_one
            assign addr_o[i] = in_cycle;
        end
    end

    // Function code and strobes.
    always_comb begin
        fc_o    = in_cycle ? FC_IACK : 3'b000;
        as_n_o  = !strobing;
        lds_n_o = !strobing;
    end
endmodule

// File: rtl/iack_vector_sel.sv
// Holds the vector: the low data byte, or the base plus the level for an autovector.
// Assumes load is asserted only on the cycle a response is accepted.
module iack_vector_sel
    import iack_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              use_auto_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [VEC_W-1:0]  vector_o
);
    logic [VEC_W-1:0] auto_vec, next_vec, vec_q;

    // Pick the vector source.
    always_comb begin
        auto_vec = VEC_W'(AUTOVEC_BASE) + VEC_W'(level_i);
        next_vec = use_auto_i ? auto_vec : data_i[VEC_W-1:0];
    end

    // Vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (load_i) vec_q <= next_vec;
    end

    assign vector_o = vec_q;
endmodule

// File: rtl/irq_ack_unit.sv
// Interrupt acknowledge cycle unit, top level.
// Assumes synchronous response inputs and that masking is done upstream.
module irq_ack_unit
    import iack_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        level_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              dtack_n_i,
    input  logic              vpa_n_i,
    input  logic              berr_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [2:0]        fc_o,
    output logic              as_n_o,
    output logic              lds_n_o,
    output logic              vector_valid_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              error_o
);
    iack_state_t      state;
    logic [LVL_W-1:0] lvl;
    logic take, use_auto, ok, err;

    iack_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .dtack_n_i(dtack_n_i), .vpa_n_i(vpa_n_i), .berr_n_i(berr_n_i),
        .state_o(state), .level_o(lvl), .take_o(take), .use_auto_o(use_auto),
        .ok_o(ok), .err_o(err)
    );

    iack_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .state_i(state), .level_i(lvl), .addr_o(addr_o), .fc_o(fc_o),
        .as_n_o(as_n_o), .lds_n_o(lds_n_o)
    );

    iack_vector_sel #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
        .clk(clk), .rst_n(rst_n), .load_i(take), .use_auto_i(use_auto),
        .level_i(lvl), .data_i(data_i), .vector_o(vector_o)
    );

    assign vector_valid_o = ok;
    assign error_o        = err;

    // R4: the two strobes always move together.
    a_r4_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
        as_n_o == lds_n_o);
    // R3: while strobing, lines 3..1 are nonzero and all other lines are high.
    a_r3_addr_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n_o |-> ((addr_o | ADDR_W'(4'b1110)) == '1 && addr_o[3:1] != 3'd0 && fc_o == 3'b111));
    // R8/R9: a result is either a vector or an error, never both.
    a_r8_exclusive_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(vector_valid_o && error_o));
    // R10: the valid flag is a single-cycle pulse.
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid_o |=> !vector_valid_o);
    // R7: an autovector completion carries the base plus the level still on the address lines.
    a_r7_autovector: assert property (@(posedge clk) disable iff (!rst_n)
        (vector_valid_o && $past(!vpa_n_i)) |-> (vector_o == VEC_W'(8'h18) + VEC_W'(addr_o[3:1])));
    // R4: strobes are released in the completion cycle.
    a_r4_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (vector_valid_o || error_o) |-> (as_n_o && lds_n_o));
endmodule

// File: tb/irq_ack_unit_test.sv
module irq_ack_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  level_i = 3'd0;
    logic [15:0] data_i = 16'h0000;
    logic        dtack_n_i = 1'b1, vpa_n_i = 1'b1, berr_n_i = 1'b1;
    logic [23:0] addr_o;
    logic [2:0]  fc_o;
    logic        as_n_o, lds_n_o, vector_valid_o, error_o;
    logic [7:0]  vector_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_ack_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .data_i(data_i), .dtack_n_i(dtack_n_i), .vpa_n_i(vpa_n_i),
        .berr_n_i(berr_n_i), .addr_o(addr_o), .fc_o(fc_o), .as_n_o(as_n_o),
        .lds_n_o(lds_n_o), .vector_valid_o(vector_valid_o),
        .vector_o(vector_o), .error_o(error_o)
    );

    // Response kinds: 0 data ack, 1 autovector, 2 bus error, 3 both acks, 4 bus error + data ack
    localparam int NV = 9;
    localparam logic [2:0]  T_LVL  [NV] = '{3'd1, 3'd7, 3'd3, 3'd5, 3'd2, 3'd6, 3'd4, 3'd7, 3'd1};
    localparam int          T_RESP [NV] = '{0, 1, 0, 1, 2, 3, 4, 0, 1};
    localparam logic [15:0] T_DATA [NV] = '{16'hAB40, 16'h1234, 16'hFF00, 16'h00FF,
                                            16'h5555, 16'h0042, 16'h0077, 16'hC3FF, 16'h9999};
    localparam int          T_WAIT [NV] = '{0, 0, 3, 5, 1, 0, 2, 17, 4};

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_addr(logic [2:0] l);
        logic [23:0] a;
        a = '1;
        a[3:1] = l;
        return a;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // Runs one acknowledge cycle and checks each phase.
    task automatic run_ack(logic [2:0] lvl, int resp, logic [15:0] dat, int waits, bit start_mid);
        logic [7:0] exp_vec;
        bit exp_err;
        exp_err = (resp >= 2);
        exp_vec = (resp == 1) ? 8'h18 + {5'd0, lvl} : dat[7:0];
        start_i = 1'b1; level_i = lvl;
        step();
        start_i = 1'b0; level_i = 3'd0;
        // address phase
        check(addr_o == exp_addr(lvl) && fc_o == 3'b111, "R3 addr/fc", {5'd0, fc_o, addr_o}, {8'h07, exp_addr(lvl)});
        check(as_n_o && lds_n_o, "R4 strobes high in address phase", {as_n_o, lds_n_o}, 2'b11);
        step();
        check(!as_n_o && !lds_n_o, "R4 strobes low", {as_n_o, lds_n_o}, 2'b00);
        step();
        for (int w = 0; w < waits; w++) begin
            if (start_mid && w == 0) begin start_i = 1'b1; level_i = 3'd2; end
            step();
            start_i = 1'b0; level_i = 3'd0;
            check(!as_n_o && !vector_valid_o && !error_o && addr_o == exp_addr(lvl),
                  "R5 wait state", {as_n_o, vector_valid_o, error_o}, 3'b000);
        end
        data_i = dat;
        dtack_n_i = !(resp == 0 || resp == 3 || resp == 4);
        vpa_n_i   = !(resp == 1 || resp == 3);
        berr_n_i  = !(resp == 2 || resp == 4);
        step();
        dtack_n_i = 1'b1; vpa_n_i = 1'b1; berr_n_i = 1'b1;
        data_i = $urandom;
        check(as_n_o && lds_n_o, "R4 release on completion", {as_n_o, lds_n_o}, 2'b11);
        if (exp_err)
            check(error_o && !vector_valid_o, resp == 3 ? "R9 both acks" : "R8 bus error",
                  {error_o, vector_valid_o}, 2'b10);
        else
            check(vector_valid_o && !error_o && vector_o == exp_vec,
                  resp == 1 ? "R7 autovector" : "R6 data vector",
                  {error_o, vector_valid_o, vector_o}, {2'b01, exp_vec});
        step();
        check(!vector_valid_o && !error_o && as_n_o && addr_o == '0 && fc_o == 3'b000,
              "R10 single pulse then idle", {vector_valid_o, error_o, fc_o}, 5'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state, with start held high during reset
        start_i = 1'b1; level_i = 3'd5;
        repeat (3) step();
        check(as_n_o && lds_n_o && !vector_valid_o && !error_o && fc_o == 3'b000 && addr_o == '0,
              "R1 reset", {as_n_o, lds_n_o, vector_valid_o, error_o, fc_o}, 7'b1100000);
        start_i = 1'b0; level_i = 3'd0;
        rst_n = 1'b1;
        step();
        check(as_n_o && !vector_valid_o && fc_o == 3'b000, "R1 after reset", {as_n_o, fc_o}, 4'b1000);

        for (int k = 0; k < NV; k++)
            run_ack(T_LVL[k], T_RESP[k], T_DATA[k], T_WAIT[k], 1'b0);

        // R2: level 0 start ignored; responses while idle ignored (R5)
        start_i = 1'b1; level_i = 3'd0;
        dtack_n_i = 1'b0; vpa_n_i = 1'b0;
        step();
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(as_n_o && fc_o == 3'b000 && !vector_valid_o && !error_o,
                  "R2 zero level ignored", {as_n_o, fc_o, vector_valid_o, error_o}, 6'b100000);
            step();
        end
        dtack_n_i = 1'b1; vpa_n_i = 1'b1;
        step();

        // R2: start during a wait phase ignored; level stays on the bus
        run_ack(3'd6, 1, 16'h0, 6, 1'b1);
        // R10: back-to-back start accepted in the idle cycle after completion
        run_ack(3'd3, 0, 16'hEE21, 0, 1'b0);
        run_ack(3'd1, 1, 16'h0, 0, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule